// File: doc/BRIEF.md
# Tagged Translation Cache with Address-Space Identifiers

This block caches finished address translations for a DMA remapping unit. Every stored translation carries a four-part tag: the requester's source ID, its process address-space identifier (PASID), the page-table level the translation was found at, and the guest frame number. The payload is the leaf page-table entry, the read and write permissions, the domain ID and the page mask. Up to three page sizes are supported: 4 KiB at level 1, 2 MiB at level 2 and 1 GiB at level 3. The storage is fully associative.

A lookup presents a source ID, an optional PASID and an input address. The block probes the three page sizes in one cycle and registers the answer. A page walker fills the cache through a separate port once it has resolved a miss. Software-driven invalidation removes every entry, every entry of one domain, or the entries of one domain that overlap a range of pages. The domain and page forms can also be limited to a single PASID.

The response register is a small state machine with three states. `RSP_IDLE` means no lookup was issued in the previous cycle. `RSP_MISS` means the previous lookup found nothing. `RSP_HIT` means the previous lookup found an entry. Each cycle the next state is chosen from that cycle's request: no request goes to `RSP_IDLE`, a request with a match goes to `RSP_HIT`, and a request without one goes to `RSP_MISS`. Any state can move to any other.

Top module: `pasid_tlb`

## Requirements
- R1: A lookup hits an entry only when source ID, effective PASID, level and frame number all match that entry.
- R2: The frame number is the input address with the offset of the entry's page size cleared, shifted right by 12. So a level-2 entry answers any address in its 2 MiB region, and a level-3 entry answers any address in its 1 GiB region.
- R3: A lookup tries level 1, then level 2, then level 3, and returns the lowest-level hit. Fill levels are encoded 1, 2 and 3. Any other level code is ignored.
- R4: A hit returns the stored page-table entry, read flag, write flag, domain ID and level. It also returns the page mask, which keeps the address bits above the page offset: bits 11:0 clear for level 1, bits 20:0 clear for level 2, bits 29:0 clear for level 3.
- R5: A fill whose tag equals the tag of a stored entry overwrites that entry. A later lookup then returns the new data.
- R6: The effective PASID of a request that carries no PASID depends on the mode. When scalable mode is off it is all ones (20'hFFFFF). When scalable mode is on it is the default PASID supplied with the lookup.
- R7: Suppose every slot is valid after this cycle's invalidation, and a fill arrives whose tag matches no entry. The cache then drops all entries and keeps only the new one.
- R8: Invalidation kind 2'b00 removes every entry.
- R9: Invalidation kind 2'b01 removes the entries whose domain matches. When PASID qualification is set, an entry must also match the given PASID to be removed.
- R10: Invalidation kind 2'b10 removes entries of the given domain (PASID-qualified as in R9) in either of two cases: the entry's frame lies within the 2^am aligned 4 KiB pages around the invalidation address, or the entry's page contains that address. The field am is 6 bits wide. Kind 2'b11 does nothing.
- R11: The answer appears on the outputs in the cycle after the request, and only then. A fill or an invalidation in the same cycle as the lookup takes effect before the lookup is made.
- R12: After reset no entry is valid and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scalable_mode | input | 1 | Selects the default-PASID rule for requests without a PASID |
| lk_req | input | 1 | Lookup request |
| lk_sid | input | SID_W | Lookup source ID |
| lk_pasid_valid | input | 1 | Lookup carries a PASID |
| lk_pasid | input | PASID_W | Lookup PASID |
| lk_default_pasid | input | PASID_W | Default PASID from the context entry |
| lk_addr | input | AW | Lookup input address |
| fill_valid | input | 1 | Insert a translation |
| fill_sid | input | SID_W | Fill source ID |
| fill_pasid | input | PASID_W | Fill PASID (effective value) |
| fill_level | input | 2 | Fill level, 1..3 |
| fill_addr | input | AW | Address that was walked |
| fill_pte | input | PTE_W | Leaf page-table entry |
| fill_rd | input | 1 | Read allowed |
| fill_wr | input | 1 | Write allowed |
| fill_did | input | DID_W | Domain ID |
| inv_valid | input | 1 | Invalidate request |
| inv_kind | input | 2 | 00 all, 01 domain, 10 pages, 11 none |
| inv_did | input | DID_W | Domain to invalidate |
| inv_pasid_qual | input | 1 | Restrict invalidation to one PASID |
| inv_pasid | input | PASID_W | PASID for restriction |
| inv_addr | input | AW | Base address of page range |
| inv_am | input | 6 | Range is 2^am pages |
| lk_rsp_valid | output | 1 | Response present |
| lk_hit | output | 1 | Response is a hit |
| lk_pte | output | PTE_W | Hit page-table entry |
| lk_rd | output | 1 | Hit read flag |
| lk_wr | output | 1 | Hit write flag |
| lk_did | output | DID_W | Hit domain ID |
| lk_level | output | 2 | Hit level |
| lk_page_mask | output | AW | Hit page mask |

## Verification
Corruption of the tag store shows up on the very next lookup of the affected page. It appears as a hit that should have missed or a miss that should have hit, and lk_pte names the slot that supplied the data. An error in the order of same-cycle updates shows within one cycle, because a lookup issued together with a fill or an invalidation must already reflect it. A wrong choice of replacement slot or flush only appears once the store is full. For that reason the bench fills the store to capacity and probes the oldest entry after one more fill.

// File: rtl/pasid_tlb_pkg.sv
package pasid_tlb_pkg;

    typedef enum logic [1:0] {
        INV_ALL    = 2'b00,
        INV_DOMAIN = 2'b01,
        INV_PAGES  = 2'b10,
        INV_NONE   = 2'b11
    } inv_kind_e;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'b00,
        RSP_MISS = 2'b01,
        RSP_HIT  = 2'b10
    } rsp_state_e;

    // Frame-number bits kept for a page of the given level (1..3).
    function automatic logic [63:0] frame_keep(input logic [1:0] lvl);
        case (lvl)
            2'd2:    frame_keep = {64{1'b1}} << 9;
            2'd3:    frame_keep = {64{1'b1}} << 18;
            default: frame_keep = {64{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/tlb_probe_cmp.sv
module tlb_probe_cmp #(
    parameter int SID_W   = 16,
    parameter int PASID_W = 20,
    parameter int GFN_W   = 36
) (
    input  logic               e_vld,
    input  logic [SID_W-1:0]   e_sid,
    input  logic [PASID_W-1:0] e_pasid,
    input  logic [1:0]         e_lvl,
    input  logic [GFN_W-1:0]   e_gfn,
    input  logic [SID_W-1:0]   q_sid,
    input  logic [PASID_W-1:0] q_pasid,
    input  logic [GFN_W-1:0]   q_gfn,
    output logic [2:0]         hit_lvl
);
    import pasid_tlb_pkg::*;

    logic owner_eq;
    assign owner_eq = e_vld && (e_sid == q_sid) && (e_pasid == q_pasid);

    for (genvar l = 0; l < 3; l++) begin : g_lvl
        logic [63:0]      keep_w;
        logic [GFN_W-1:0] keep;
        assign keep_w = frame_keep(2'(l + 1));
        assign keep   = keep_w[GFN_W-1:0];
        assign hit_lvl[l] = owner_eq && (e_lvl == 2'(l + 1)) &&
                            (e_gfn == (q_gfn & keep));
    end

endmodule

// File: rtl/tlb_inv_cmp.sv
module tlb_inv_cmp #(
    parameter int PASID_W = 20,
    parameter int DID_W   = 16,
    parameter int GFN_W   = 36
) (
    input  logic               e_vld,
    input  logic [PASID_W-1:0] e_pasid,
    input  logic [DID_W-1:0]   e_did,
    input  logic [1:0]         e_lvl,
    input  logic [GFN_W-1:0]   e_gfn,
    input  logic               inv_valid,
    input  logic [1:0]         inv_kind,
    input  logic [DID_W-1:0]   inv_did,
    input  logic               inv_pasid_qual,
    input  logic [PASID_W-1:0] inv_pasid,
    input  logic [GFN_W-1:0]   inv_gfn,
    input  logic [5:0]         inv_am,
    output logic               kill
);
    import pasid_tlb_pkg::*;

    logic [GFN_W-1:0] range_keep;
    logic [63:0]      lvl_keep_w;
    logic             owner_ok;
    logic             page_ok;

    always_comb begin
        for (int i = 0; i < GFN_W; i++) begin
            range_keep[i] = (i >= int'(inv_am));
        end
    end

    assign lvl_keep_w = frame_keep(e_lvl);
    assign owner_ok   = (e_did == inv_did) &&
                        (!inv_pasid_qual || (e_pasid == inv_pasid));
    assign page_ok    = ((e_gfn & range_keep) == (inv_gfn & range_keep)) ||
                        (e_gfn == (inv_gfn & lvl_keep_w[GFN_W-1:0]));

    always_comb begin
        kill = 1'b0;
        if (inv_valid && e_vld) begin
            unique case (inv_kind_e'(inv_kind))
                INV_ALL:    kill = 1'b1;
                INV_DOMAIN: kill = owner_ok;
                INV_PAGES:  kill = owner_ok && page_ok;
                INV_NONE:   kill = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pasid_tlb.sv
module pasid_tlb #(
    parameter int ENTRIES = 8,
    parameter int AW      = 48,
    parameter int SID_W   = 16,
    parameter int PASID_W = 20,
    parameter int DID_W   = 16,
    parameter int PTE_W   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scalable_mode,
    input  logic               lk_req,
    input  logic [SID_W-1:0]   lk_sid,
    input  logic               lk_pasid_valid,
    input  logic [PASID_W-1:0] lk_pasid,
    input  logic [PASID_W-1:0] lk_default_pasid,
    input  logic [AW-1:0]      lk_addr,
    input  logic               fill_valid,
    input  logic [SID_W-1:0]   fill_sid,
    input  logic [PASID_W-1:0] fill_pasid,
    input  logic [1:0]         fill_level,
    input  logic [AW-1:0]      fill_addr,
    input  logic [PTE_W-1:0]   fill_pte,
    input  logic               fill_rd,
    input  logic               fill_wr,
    input  logic [DID_W-1:0]   fill_did,
    input  logic               inv_valid,
    input  logic [1:0]         inv_kind,
    input  logic [DID_W-1:0]   inv_did,
    input  logic               inv_pasid_qual,
    input  logic [PASID_W-1:0] inv_pasid,
    input  logic [AW-1:0]      inv_addr,
    input  logic [5:0]         inv_am,
    output logic               lk_rsp_valid,
    output logic               lk_hit,
    output logic [PTE_W-1:0]   lk_pte,
    output logic               lk_rd,
    output logic               lk_wr,
    output logic [DID_W-1:0]   lk_did,
    output logic [1:0]         lk_level,
    output logic [AW-1:0]      lk_page_mask
);
    import pasid_tlb_pkg::*;

    localparam int GFN_W = AW - 12;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PASID_W-1:0] NO_PASID = {PASID_W{1'b1}};

    typedef struct packed {
        logic               vld;
        logic [SID_W-1:0]   sid;
        logic [PASID_W-1:0] pasid;
        logic [1:0]         lvl;
        logic [GFN_W-1:0]   gfn;
        logic [PTE_W-1:0]   pte;
        logic               rd;
        logic               wr;
        logic [DID_W-1:0]   did;
    } entry_t;

    entry_t ent_q   [ENTRIES];
    entry_t ent_inv [ENTRIES];
    entry_t ent_d   [ENTRIES];
    entry_t new_ent;

    logic [ENTRIES-1:0] kill;
    logic [ENTRIES-1:0] free_vec;
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] sel_vec;
    logic [2:0]         fhit [ENTRIES];
    logic [2:0]         lhit [ENTRIES];

    logic               match_found, free_found, hit_found;
    logic [IDX_W-1:0]   match_idx, free_idx, hit_idx;
    logic               fill_ok;
    logic [PASID_W-1:0] eff_pasid;
    logic [63:0]        fill_keep_w;
    logic [2:0]         lvl_any;
    logic [1:0]         hit_lvl_sel;
    logic               hit_any;

    rsp_state_e         rsp_q, rsp_d;
    entry_t             rsp_ent_q;

    // Effective PASID of the lookup.
    always_comb begin
        if (lk_pasid_valid)     eff_pasid = lk_pasid;
        else if (scalable_mode) eff_pasid = lk_default_pasid;
        else                    eff_pasid = NO_PASID;
    end

    assign fill_ok     = fill_valid && (fill_level != 2'd0);
    assign fill_keep_w = frame_keep(fill_level);

    always_comb begin
        new_ent       = '0;
        new_ent.vld   = 1'b1;
        new_ent.sid   = fill_sid;
        new_ent.pasid = fill_pasid;
        new_ent.lvl   = fill_level;
        new_ent.gfn   = fill_addr[AW-1:12] & fill_keep_w[GFN_W-1:0];
        new_ent.pte   = fill_pte;
        new_ent.rd    = fill_rd;
        new_ent.wr    = fill_wr;
        new_ent.did   = fill_did;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_inv_cmp #(.PASID_W(PASID_W), .DID_W(DID_W), .GFN_W(GFN_W)) u_inv (
            .e_vld          (ent_q[g].vld),
            .e_pasid        (ent_q[g].pasid),
            .e_did          (ent_q[g].did),
            .e_lvl          (ent_q[g].lvl),
            .e_gfn          (ent_q[g].gfn),
            .inv_valid      (inv_valid),
            .inv_kind       (inv_kind),
            .inv_did        (inv_did),
            .inv_pasid_qual (inv_pasid_qual),
            .inv_pasid      (inv_pasid),
            .inv_gfn        (inv_addr[AW-1:12]),
            .inv_am         (inv_am),
            .kill           (kill[g])
        );

        tlb_probe_cmp #(.SID_W(SID_W), .PASID_W(PASID_W), .GFN_W(GFN_W)) u_fprobe (
            .e_vld   (ent_inv[g].vld),
            .e_sid   (ent_inv[g].sid),
            .e_pasid (ent_inv[g].pasid),
            .e_lvl   (ent_inv[g].lvl),
            .e_gfn   (ent_inv[g].gfn),
            .q_sid   (fill_sid),
            .q_pasid (fill_pasid),
            .q_gfn   (fill_addr[AW-1:12]),
            .hit_lvl (fhit[g])
        );

        tlb_probe_cmp #(.SID_W(SID_W), .PASID_W(PASID_W), .GFN_W(GFN_W)) u_lprobe (
            .e_vld   (ent_d[g].vld),
            .e_sid   (ent_d[g].sid),
            .e_pasid (ent_d[g].pasid),
            .e_lvl   (ent_d[g].lvl),
            .e_gfn   (ent_d[g].gfn),
            .q_sid   (lk_sid),
            .q_pasid (eff_pasid),
            .q_gfn   (lk_addr[AW-1:12]),
            .hit_lvl (lhit[g])
        );
    end

    // Stage 1: invalidation.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_inv[i]     = ent_q[i];
            ent_inv[i].vld = ent_q[i].vld && !kill[i];
            free_vec[i]    = !(ent_q[i].vld && !kill[i]);
        end
    end

    // Tag match of the fill at its own level.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            case (fill_level)
                2'd1:    match_vec[i] = fhit[i][0];
                2'd2:    match_vec[i] = fhit[i][1];
                2'd3:    match_vec[i] = fhit[i][2];
                default: match_vec[i] = 1'b0;
            endcase
        end
    end

    tlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_match (
        .req(match_vec), .found(match_found), .idx(match_idx));
    tlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_free (
        .req(free_vec), .found(free_found), .idx(free_idx));

    // Stage 2: fill (replace, allocate, or flush then allocate).
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) ent_d[i] = ent_inv[i];
        if (fill_ok) begin
            if (match_found) begin
                ent_d[match_idx] = new_ent;
            end else if (free_found) begin
                ent_d[free_idx] = new_ent;
            end else begin
                for (int i = 0; i < ENTRIES; i++) ent_d[i].vld = 1'b0;
                ent_d[0] = new_ent;
            end
        end
    end

    // Stage 3: lookup on the updated store, lowest level first.
    always_comb begin
        lvl_any = '0;
        for (int i = 0; i < ENTRIES; i++) lvl_any = lvl_any | lhit[i];
        if (lvl_any[0])      hit_lvl_sel = 2'd0;
        else if (lvl_any[1]) hit_lvl_sel = 2'd1;
        else                 hit_lvl_sel = 2'd2;
        hit_any = |lvl_any;
        for (int i = 0; i < ENTRIES; i++) sel_vec[i] = lhit[i][hit_lvl_sel];
    end

    tlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_hit (
        .req(sel_vec), .found(hit_found), .idx(hit_idx));

    always_comb begin
        rsp_d = RSP_IDLE;
        unique case (rsp_q)
            RSP_IDLE, RSP_MISS, RSP_HIT: begin
                if (lk_req) rsp_d = (hit_any && hit_found) ? RSP_HIT : RSP_MISS;
                else        rsp_d = RSP_IDLE;
            end
            default: rsp_d = RSP_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= RSP_IDLE;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    // Store and response data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
            rsp_ent_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
            if (lk_req && hit_any) rsp_ent_q <= ent_d[hit_idx];
        end
    end

    // Outputs from state.
    always_comb begin
        lk_rsp_valid = 1'b0;
        lk_hit       = 1'b0;
        unique case (rsp_q)
            RSP_IDLE: ;
            RSP_MISS: lk_rsp_valid = 1'b1;
            RSP_HIT: begin
                lk_rsp_valid = 1'b1;
                lk_hit       = 1'b1;
            end
            default: ;
        endcase
    end

    logic [63:0] rsp_keep_w;
    assign rsp_keep_w   = frame_keep(rsp_ent_q.lvl);
    assign lk_pte       = lk_hit ? rsp_ent_q.pte : '0;
    assign lk_rd        = lk_hit && rsp_ent_q.rd;
    assign lk_wr        = lk_hit && rsp_ent_q.wr;
    assign lk_did       = lk_hit ? rsp_ent_q.did : '0;
    assign lk_level     = lk_hit ? rsp_ent_q.lvl : 2'd0;
    assign lk_page_mask = lk_hit ? {rsp_keep_w[GFN_W-1:0], 12'h000} : '0;

endmodule

// File: rtl/pasid_tlb_chk.sv
module pasid_tlb_chk #(
    parameter int AW      = 48,
    parameter int SID_W   = 16,
    parameter int PASID_W = 20,
    parameter int DID_W   = 16,
    parameter int PTE_W   = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_req,
    input logic [SID_W-1:0]   lk_sid,
    input logic               lk_pasid_valid,
    input logic [PASID_W-1:0] lk_pasid,
    input logic [AW-1:0]      lk_addr,
    input logic               fill_valid,
    input logic [SID_W-1:0]   fill_sid,
    input logic [PASID_W-1:0] fill_pasid,
    input logic [1:0]         fill_level,
    input logic [AW-1:0]      fill_addr,
    input logic [PTE_W-1:0]   fill_pte,
    input logic               inv_valid,
    input logic [1:0]         inv_kind,
    input logic               lk_rsp_valid,
    input logic               lk_hit,
    input logic [PTE_W-1:0]   lk_pte,
    input logic [1:0]         lk_level,
    input logic [AW-1:0]      lk_page_mask
);
    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_rsp_valid);

    // R11
    rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_rsp_valid);

    // R4
    hit_level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_rsp_valid && lk_level != 2'd0));

    // R4
    small_page_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_level == 2'd1) |-> (lk_page_mask[11:0] == 12'h0 && (&lk_page_mask[AW-1:12])));

    // R8
    inv_all_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && inv_valid && inv_kind == 2'b00 && !fill_valid) |=> !lk_hit);

    // R11
    fill_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && fill_valid && !inv_valid && lk_pasid_valid && lk_pasid == fill_pasid &&
         lk_sid == fill_sid && fill_level == 2'd1 && lk_addr[AW-1:12] == fill_addr[AW-1:12])
        |=> (lk_hit && lk_pte == $past(fill_pte)));
endmodule

bind pasid_tlb pasid_tlb_chk #(
    .AW(AW), .SID_W(SID_W), .PASID_W(PASID_W), .DID_W(DID_W), .PTE_W(PTE_W)
) u_chk (.*);

// File: tb/pasid_tlb_tb.sv
module pasid_tlb_tb;
    localparam int AW = 48;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        scalable_mode = 0;
    logic        lk_req = 0, lk_pasid_valid = 0;
    logic [15:0] lk_sid = 0;
    logic [19:0] lk_pasid = 0, lk_default_pasid = 0;
    logic [47:0] lk_addr = 0;
    logic        fill_valid = 0, fill_rd = 0, fill_wr = 0;
    logic [15:0] fill_sid = 0, fill_did = 0;
    logic [19:0] fill_pasid = 0;
    logic [1:0]  fill_level = 0;
    logic [47:0] fill_addr = 0;
    logic [63:0] fill_pte = 0;
    logic        inv_valid = 0, inv_pasid_qual = 0;
    logic [1:0]  inv_kind = 2'b11;
    logic [15:0] inv_did = 0;
    logic [19:0] inv_pasid = 0;
    logic [47:0] inv_addr = 0;
    logic [5:0]  inv_am = 0;
    logic        lk_rsp_valid, lk_hit, lk_rd, lk_wr;
    logic [63:0] lk_pte;
    logic [15:0] lk_did;
    logic [1:0]  lk_level;
    logic [47:0] lk_page_mask;

    pasid_tlb #(.ENTRIES(DEPTH)) u_dut (.*);

    int checks = 0;
    int failures = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lookup(input [15:0] sid, input pv, input [19:0] p, input [47:0] a);
        @(negedge clk);
        lk_req = 1; lk_sid = sid; lk_pasid_valid = pv; lk_pasid = p; lk_addr = a;
        @(negedge clk);
        lk_req = 0;
    endtask

    task automatic set_fill(input [15:0] sid, input [19:0] p, input [1:0] lvl,
                            input [47:0] a, input [63:0] pte, input [15:0] did);
        fill_sid = sid; fill_pasid = p; fill_level = lvl; fill_addr = a;
        fill_pte = pte; fill_did = did; fill_rd = 1; fill_wr = 0;
    endtask

    task automatic fill(input [15:0] sid, input [19:0] p, input [1:0] lvl,
                        input [47:0] a, input [63:0] pte, input [15:0] did);
        @(negedge clk);
        set_fill(sid, p, lvl, a, pte, did);
        fill_valid = 1;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic inval(input [1:0] kind, input [15:0] did, input pq, input [19:0] p,
                         input [47:0] a, input [5:0] am);
        @(negedge clk);
        inv_valid = 1; inv_kind = kind; inv_did = did; inv_pasid_qual = pq;
        inv_pasid = p; inv_addr = a; inv_am = am;
        @(negedge clk);
        inv_valid = 0;
    endtask

    task automatic expect_hit(input string req, input logic [63:0] pte);
        check(lk_rsp_valid && lk_hit && lk_pte == pte, req, {lk_hit, lk_pte[62:0]}, {1'b1, pte[62:0]});
    endtask

    task automatic expect_miss(input string req);
        check(lk_rsp_valid && !lk_hit, req, {63'd0, lk_hit}, 64'd0);
    endtask

    // {sid16, pasid_valid1, pasid20, addr48, hit1, pte8}
    localparam int NV = 11;
    localparam logic [93:0] VEC [NV] = '{
        {16'h0100, 1'b1, 20'h00005, 48'h0000_1234_5abc, 1'b1, 8'hA1},
        {16'h0100, 1'b1, 20'h00006, 48'h0000_1234_5abc, 1'b0, 8'h00},
        {16'h0101, 1'b1, 20'h00005, 48'h0000_1234_5abc, 1'b0, 8'h00},
        {16'h0100, 1'b1, 20'h00005, 48'h0000_1234_6000, 1'b0, 8'h00},
        {16'h0100, 1'b1, 20'h00005, 48'h0000_4010_0000, 1'b1, 8'hB2},
        {16'h0100, 1'b1, 20'h00005, 48'h0000_4000_2ff0, 1'b1, 8'hE5},
        {16'h0100, 1'b1, 20'h00005, 48'h0000_4020_0000, 1'b0, 8'h00},
        {16'h0100, 1'b1, 20'h00005, 48'h0000_bfff_fff0, 1'b1, 8'hD4},
        {16'h0200, 1'b0, 20'h00000, 48'h0000_0000_3008, 1'b1, 8'hC3},
        {16'h0200, 1'b1, 20'h00000, 48'h0000_0000_3008, 1'b0, 8'h00},
        {16'h0100, 1'b1, 20'h00005, 48'h0000_c000_0000, 1'b0, 8'h00}
    };

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12: reset state
        @(negedge clk);
        check(!lk_rsp_valid, "R12 idle", {63'd0, lk_rsp_valid}, 64'd0);
        lookup(16'h0100, 1, 20'h5, 48'h1234_5000);
        expect_miss("R12 empty");

        fill(16'h0100, 20'h5, 2'd1, 48'h1234_5000, 64'hA1, 16'd7);
        fill(16'h0100, 20'h5, 2'd2, 48'h4000_0000, 64'hB2, 16'd7);
        fill(16'h0200, 20'hFFFFF, 2'd1, 48'h0000_3000, 64'hC3, 16'd9);
        fill(16'h0100, 20'h5, 2'd3, 48'h8000_0000, 64'hD4, 16'd8);
        fill(16'h0100, 20'h5, 2'd1, 48'h4000_2000, 64'hE5, 16'd7);

        // R1 R2 R3 R6: vector walk
        for (int v = 0; v < NV; v++) begin
            lookup(VEC[v][93:78], VEC[v][77], VEC[v][76:57], VEC[v][56:9]);
            if (VEC[v][8]) expect_hit($sformatf("R1/R2/R3/R6 vec%0d", v), {56'd0, VEC[v][7:0]});
            else           expect_miss($sformatf("R1/R2/R3/R6 vec%0d", v));
        end

        // R4: payload and masks
        lookup(16'h0100, 1, 20'h5, 48'h1234_5000);
        check(lk_did == 16'd7 && lk_rd && !lk_wr && lk_level == 2'd1, "R4 fields",
              {lk_did, 14'd0, lk_level, lk_rd, lk_wr}, {16'd7, 14'd0, 2'd1, 1'b1, 1'b0});
        check(lk_page_mask == 48'hFFFF_FFFF_F000, "R4 mask L1", {16'd0, lk_page_mask}, 64'hFFFF_FFFF_F000);
        lookup(16'h0100, 1, 20'h5, 48'h4010_0000);
        check(lk_page_mask == 48'hFFFF_FFE0_0000 && lk_level == 2'd2, "R4 mask L2",
              {16'd0, lk_page_mask}, 64'hFFFF_FFE0_0000);
        lookup(16'h0100, 1, 20'h5, 48'h9000_0000);
        check(lk_page_mask == 48'hFFFF_C000_0000 && lk_level == 2'd3, "R4 mask L3",
              {16'd0, lk_page_mask}, 64'hFFFF_C000_0000);

        // R6: scalable mode uses default PASID
        scalable_mode = 1; lk_default_pasid = 20'h5;
        lookup(16'h0100, 0, 20'h0, 48'h1234_5000);
        expect_hit("R6 scalable default", 64'hA1);
        lk_default_pasid = 20'h0;
        lookup(16'h0200, 0, 20'h0, 48'h0000_3008);
        expect_miss("R6 scalable not all-ones");
        scalable_mode = 0;

        // R5: replace on equal tag
        fill(16'h0100, 20'h5, 2'd1, 48'h1234_5000, 64'h99, 16'd7);
        lookup(16'h0100, 1, 20'h5, 48'h1234_5000);
        expect_hit("R5 replaced", 64'h99);

        // R10: page-selective
        inval(2'b10, 16'd7, 0, 20'h0, 48'h1234_4000, 6'd1);
        lookup(16'h0100, 1, 20'h5, 48'h1234_5000);
        expect_miss("R10 range am=1");
        lookup(16'h0100, 1, 20'h5, 48'h4000_2ff0);
        expect_hit("R10 outside range kept", 64'hE5);
        inval(2'b10, 16'd9, 0, 20'h0, 48'h8000_0000, 6'd0);
        lookup(16'h0100, 1, 20'h5, 48'h8000_0000);
        expect_hit("R10 other domain kept", 64'hD4);
        inval(2'b10, 16'd7, 1, 20'h6, 48'h4000_2000, 6'd0);
        lookup(16'h0100, 1, 20'h5, 48'h4000_2ff0);
        expect_hit("R10 pasid qualifier mismatch kept", 64'hE5);
        inval(2'b10, 16'd7, 1, 20'h5, 48'h4000_2000, 6'd0);
        lookup(16'h0100, 1, 20'h5, 48'h4000_2ff0);
        expect_miss("R10 pasid qualified removed");
        lookup(16'h0100, 1, 20'h5, 48'h4010_0000);
        expect_miss("R10 large page containing address removed");
        inval(2'b11, 16'd8, 0, 20'h0, 48'h0, 6'd0);
        lookup(16'h0100, 1, 20'h5, 48'h8000_0000);
        expect_hit("R10 kind 11 no effect", 64'hD4);

        // R9: domain
        inval(2'b01, 16'd8, 0, 20'h0, 48'h0, 6'd0);
        lookup(16'h0100, 1, 20'h5, 48'h8000_0000);
        expect_miss("R9 domain removed");
        lookup(16'h0200, 0, 20'h0, 48'h0000_3000);
        expect_hit("R9 other domain kept", 64'hC3);

        // R11: same-cycle fill and lookup
        @(negedge clk);
        set_fill(16'h0300, 20'h1, 2'd1, 48'h5000, 64'h55, 16'd3);
        fill_valid = 1;
        lk_req = 1; lk_sid = 16'h0300; lk_pasid_valid = 1; lk_pasid = 20'h1; lk_addr = 48'h5010;
        @(negedge clk);
        fill_valid = 0; lk_req = 0;
        expect_hit("R11 fill before lookup", 64'h55);
        @(negedge clk);
        check(!lk_rsp_valid, "R11 one cycle only", {63'd0, lk_rsp_valid}, 64'd0);

        // R8: flush all with same-cycle lookup
        @(negedge clk);
        inv_valid = 1; inv_kind = 2'b00;
        lk_req = 1; lk_sid = 16'h0200; lk_pasid_valid = 0; lk_addr = 48'h3000;
        @(negedge clk);
        inv_valid = 0; lk_req = 0;
        expect_miss("R8 flush same cycle");
        lookup(16'h0300, 1, 20'h1, 48'h5000);
        expect_miss("R8 flush all");

        // R7: capacity
        for (int i = 0; i < DEPTH; i++)
            fill(16'h0400, 20'h1, 2'd1, 48'(i) << 12, 64'h10 + 64'(i), 16'd1);
        lookup(16'h0400, 1, 20'h1, 48'h0);
        expect_hit("R7 full store holds first", 64'h10);
        fill(16'h0400, 20'h1, 2'd1, 48'(DEPTH) << 12, 64'hF0, 16'd1);
        lookup(16'h0400, 1, 20'h1, 48'h0);
        expect_miss("R7 flushed on overflow");
        lookup(16'h0400, 1, 20'h1, 48'h1000);
        expect_miss("R7 flushed second");
        lookup(16'h0400, 1, 20'h1, 48'(DEPTH) << 12);
        expect_hit("R7 new entry kept", 64'hF0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule